// File: doc/BRIEF.md
# Video Address Distortion Engine

This block turns a pair of raster pixel counters into a read address for a frame store and a coloured output pixel, with the address path deliberately bent to make glitch effects. It sits between the display timing counters and the memory that holds the picture. By default it shows a 400×300 stored frame at twice its size. Five active-low keys pick effects, and the block samples them once per frame, on the first blanking line. The effects are a coarse bitmap view with 16×16 blocks, horizontal repetition of the left part of the picture, a sine-driven horizontal wobble, a red-channel grid overlay, and a second mirrored collage bank.

The horizontal index is an internal running value. It restarts at each line start and then advances by one step per clock. The wobble changes that step, and the repetition folds the index back. All address arithmetic clamps to the last valid location, so it never wraps into unrelated data. The memory is outside the block and has a one-cycle registered read. The block lines up its pixel qualifiers with the returned data, so `rgb` carries the colour of a pixel three clocks after its counters were presented.

Top module: `vga_fx_top`

## Requirements
- R1: Keys are active low: bit 0 bitmap view, bit 1 repetition, bit 2 wobble, bit 3 grid, bit 4 alternate bank. The block samples them only on the clock where `h_cnt` is 0 and `v_cnt` is 600, and key changes at any other time have no effect.
- R2: Frame view: with index x, `mem_addr` equals (x>>1) + (v>>1)*400 one clock after the counters, where x is 0 when `h_cnt` is 0 and otherwise the previous index plus its step.
- R3: With the alternate bank selected, the frame-view address is 30000 − (x>>1) + (v>>1)*400.
- R4: Bitmap view: the address is (x>>4) + (v>>4)*50, and the colour is 8'hFF when read bit 0 is 1 and 8'h00 otherwise.
- R5: Repetition: when an advanced index reaches 200 or more, 200 is subtracted from it, so columns from 200 onward repeat the left part of the picture.
- R6: Wobble: the index step is 1 plus the signed 4-bit `sine_ofs`, and a negative result clamps to 0. The vertical term is never affected.
- R7: Grid: for an active pixel where `h_cnt` mod 20 is 0 or `v_cnt` mod 10 is 0, rgb[7] takes read bit 4, rgb[6] takes read bit 3, and rgb[5] takes the inverse of read bit 1. The other bits are unchanged.
- R8: Outside `h_cnt` < 800 and `v_cnt` < 600, `rgb` is 0. Otherwise, without effects, `rgb` equals the read data. `rgb` appears two clocks after the address that fetched it.
- R9: Addresses clamp: the frame view never exceeds 119999 and never goes below 0, and the bitmap view never exceeds 1899. The index itself clamps at its maximum.
- R10: While reset is asserted, `mem_addr` and `rgb` are 0. After reset all effects are off until the first sampling point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cnt | input | 11 | Horizontal pixel counter |
| v_cnt | input | 11 | Vertical line counter |
| keys_n | input | 5 | Active-low effect keys |
| sine_ofs | input | 4 | Signed horizontal step offset |
| mem_rdata | input | 8 | Frame store read data, RGB 3-3-2 |
| mem_addr | output | 17 | Frame store read address |
| rgb | output | 8 | Output pixel, RGB 3-3-2 |

## Verification
Two pairs of functions can act on the same pixel. Repetition and wobble can both act in one index update, and the grid override can land on a pixel that bitmap view has already expanded to a single colour. The bench provokes both by latching random key combinations, feeding a random signed offset on every pixel, and scanning whole lines at both grid-aligned and unaligned rows. It judges each address and each pixel against a cycle model built from the requirements, and it keeps the clamp-then-fold and expand-then-override orders that the requirements define.

// File: rtl/vga_fx_pkg.sv
package vga_fx_pkg;
  localparam int PIX_W = 8;
  localparam int KEY_N = 5;

  typedef struct packed {
    logic bmp;
    logic dbl;
    logic wig;
    logic grid;
    logic alt;
  } fx_mode_t;

  localparam fx_mode_t MODE_OFF = '0;

  typedef struct packed {
    logic act;
    logic grid;
    logic bmp;
  } pix_tag_t;
endpackage

// File: rtl/vga_fx_mode.sv
module vga_fx_mode
  import vga_fx_pkg::*;
#(
  parameter int HW    = 11,
  parameter int VW    = 11,
  parameter int V_ACT = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HW-1:0]    h_cnt,
  input  logic [VW-1:0]    v_cnt,
  input  logic [KEY_N-1:0] keys_n,
  output fx_mode_t         mode_q
);
  logic     frame_edge;
  fx_mode_t mode_d;

  always_comb begin
    frame_edge  = (h_cnt == '0) && (v_cnt == VW'(V_ACT));
    mode_d.bmp  = ~keys_n[0];
    mode_d.dbl  = ~keys_n[1];
    mode_d.wig  = ~keys_n[2];
    mode_d.grid = ~keys_n[3];
    mode_d.alt  = ~keys_n[4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= MODE_OFF;
    else if (frame_edge) mode_q <= mode_d;
  end

  // R1: mode only moves on the blanking-start clock
  a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_edge |=> $stable(mode_q));
endmodule

// File: rtl/vga_fx_hindex.sv
module vga_fx_hindex #(
  parameter int HW        = 11,
  parameter int XW        = 14,
  parameter int SINE_W    = 4,
  parameter int DOUBLE_AT = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [HW-1:0]            h_cnt,
  input  logic signed [SINE_W-1:0] sine_ofs,
  input  logic                     dbl_en,
  input  logic                     wig_en,
  output logic [XW-1:0]            x_cur
);
  localparam int SW = XW + 2;
  localparam logic signed [SW-1:0] XMAX = SW'((1 << XW) - 1);

  logic [XW-1:0]        x_q, x_d;
  logic signed [SW-1:0] step, sum;

  always_comb begin
    x_cur = (h_cnt == '0) ? '0 : x_q;
    step  = wig_en ? ({{(SW-SINE_W){sine_ofs[SINE_W-1]}}, sine_ofs} + SW'(1))
                   : SW'(1);
    sum   = $signed({2'b00, x_cur}) + step;
    if (sum < 0)         x_d = '0;
    else if (sum > XMAX) x_d = '1;
    else                 x_d = sum[XW-1:0];
    if (dbl_en && (x_d >= XW'(DOUBLE_AT))) x_d = x_d - XW'(DOUBLE_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= x_d;
  end

  // R5: plain repetition keeps the running index inside the fold span
  a_r5_double_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_en && !wig_en) |-> (x_q < XW'(DOUBLE_AT)));
endmodule

// File: rtl/vga_fx_addr.sv
module vga_fx_addr
  import vga_fx_pkg::*;
#(
  parameter int XW         = 14,
  parameter int VW         = 11,
  parameter int FRAME_W    = 400,
  parameter int FRAME_H    = 300,
  parameter int BANK_OFS   = 30000,
  parameter int BMP_STRIDE = 50,
  parameter int BMP_ROWS   = 38,
  parameter int AW         = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] x_cur,
  input  logic [VW-1:0] v_cnt,
  input  fx_mode_t      mode,
  output logic [AW-1:0] addr_q
);
  localparam int SW = AW + 3;
  localparam logic signed [SW-1:0] FRAME_CAP = SW'(FRAME_W*FRAME_H - 1);
  localparam logic signed [SW-1:0] BMP_CAP   = SW'(BMP_STRIDE*BMP_ROWS - 1);

  logic signed [SW-1:0] hterm, row, frame_a, bmp_a;
  logic [AW-1:0]        addr_d;

  always_comb begin
    hterm   = $signed(SW'(x_cur >> 1));
    row     = $signed(SW'(v_cnt >> 1)) * $signed(SW'(FRAME_W));
    frame_a = mode.alt ? (SW'(BANK_OFS) - hterm + row) : (hterm + row);
    bmp_a   = $signed(SW'(x_cur >> 4)) +
              $signed(SW'(v_cnt >> 4)) * $signed(SW'(BMP_STRIDE));
    if (mode.bmp) begin
      addr_d = (bmp_a > BMP_CAP) ? BMP_CAP[AW-1:0] : bmp_a[AW-1:0];
    end else if (frame_a < 0) begin
      addr_d = '0;
    end else if (frame_a > FRAME_CAP) begin
      addr_d = FRAME_CAP[AW-1:0];
    end else begin
      addr_d = frame_a[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  // R9: no address beyond the frame store
  a_r9_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= FRAME_CAP[AW-1:0]);
  // R9: bitmap view stays inside the bitmap
  a_r9_bmp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    mode.bmp |=> (addr_q <= BMP_CAP[AW-1:0]));
endmodule

// File: rtl/vga_fx_pixel.sv
module vga_fx_pixel
  import vga_fx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pix_tag_t         tag_d,
  input  logic [PIX_W-1:0] mem_rdata,
  output logic [PIX_W-1:0] rgb_q
);
  pix_tag_t         s1_q, s2_q;
  logic [PIX_W-1:0] rgb_d;

  always_comb begin
    rgb_d = s2_q.bmp ? {PIX_W{mem_rdata[0]}} : mem_rdata;
    if (s2_q.grid) begin
      rgb_d[7] = mem_rdata[4];
      rgb_d[6] = mem_rdata[3];
      rgb_d[5] = ~mem_rdata[1];
    end
    if (!s2_q.act) rgb_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      rgb_q <= '0;
    end else begin
      s1_q  <= tag_d;
      s2_q  <= s1_q;
      rgb_q <= rgb_d;
    end
  end

  // R8: blanking pixels leave as black
  a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_q.act |=> (rgb_q == '0));
  // R4: bitmap pixels without grid are monochrome
  a_r4_bmp_mono: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q.bmp && s2_q.act && !s2_q.grid) |=> (rgb_q == '0 || rgb_q == '1));
endmodule

// File: rtl/vga_fx_top.sv
module vga_fx_top
  import vga_fx_pkg::*;
#(
  parameter int HW         = 11,
  parameter int VW         = 11,
  parameter int H_ACT      = 800,
  parameter int V_ACT      = 600,
  parameter int XW         = 14,
  parameter int SINE_W     = 4,
  parameter int DOUBLE_AT  = 200,
  parameter int FRAME_W    = 400,
  parameter int FRAME_H    = 300,
  parameter int BANK_OFS   = 30000,
  parameter int BMP_STRIDE = 50,
  parameter int BMP_ROWS   = 38,
  parameter int GRID_H     = 20,
  parameter int GRID_V     = 10,
  localparam int AW        = $clog2(FRAME_W*FRAME_H)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [HW-1:0]            h_cnt,
  input  logic [VW-1:0]            v_cnt,
  input  logic [KEY_N-1:0]         keys_n,
  input  logic signed [SINE_W-1:0] sine_ofs,
  input  logic [PIX_W-1:0]         mem_rdata,
  output logic [AW-1:0]            mem_addr,
  output logic [PIX_W-1:0]         rgb
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  fx_mode_t      mode;
  logic [XW-1:0] x_cur;
  pix_tag_t      tag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    tag_d.act  = (h_cnt < HW'(H_ACT)) && (v_cnt < VW'(V_ACT));
    tag_d.grid = mode.grid && (((h_cnt % HW'(GRID_H)) == '0) ||
                               ((v_cnt % VW'(GRID_V)) == '0));
    tag_d.bmp  = mode.bmp;
  end

  vga_fx_mode #(.HW(HW), .VW(VW), .V_ACT(V_ACT)) u_mode (
    .clk(clk), .rst_n(rst_int_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .keys_n(keys_n), .mode_q(mode));

  vga_fx_hindex #(.HW(HW), .XW(XW), .SINE_W(SINE_W), .DOUBLE_AT(DOUBLE_AT)) u_hidx (
    .clk(clk), .rst_n(rst_int_n), .h_cnt(h_cnt), .sine_ofs(sine_ofs),
    .dbl_en(mode.dbl), .wig_en(mode.wig), .x_cur(x_cur));

  vga_fx_addr #(.XW(XW), .VW(VW), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
                .BANK_OFS(BANK_OFS), .BMP_STRIDE(BMP_STRIDE),
                .BMP_ROWS(BMP_ROWS), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .x_cur(x_cur), .v_cnt(v_cnt),
    .mode(mode), .addr_q(mem_addr));

  vga_fx_pixel u_pix (
    .clk(clk), .rst_n(rst_int_n), .tag_d(tag_d),
    .mem_rdata(mem_rdata), .rgb_q(rgb));
endmodule

// File: tb/vga_fx_top_test.sv
module vga_fx_top_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [10:0]       h, v;
  logic [4:0]        keys_n;
  logic signed [3:0] sine;
  logic [7:0]        rdata;
  logic [16:0]       addr;
  logic [7:0]        rgb;

  int checks = 0;
  int fails  = 0;

  vga_fx_top uut (.clk(clk), .rst_n(rst_n), .h_cnt(h), .v_cnt(v),
    .keys_n(keys_n), .sine_ofs(sine), .mem_rdata(rdata),
    .mem_addr(addr), .rgb(rgb));

  function automatic logic [7:0] memf(int a);
    return 8'((a * 29) ^ (a >> 7));
  endfunction

  always @(posedge clk) rdata <= memf(int'(addr));

  // reference model state
  int    xm;
  bit    m_bmp, m_dbl, m_wig, m_grid, m_alt;
  int    ea;
  bit    ea_v;
  int    er [3];
  bit    ev [3];
  bit    eact [3];
  string tag;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fnext(int xc, int s);
    int sum = xc + 1 + (m_wig ? s : 0);
    if (sum < 0) sum = 0;
    if (sum > 16383) sum = 16383;
    if (m_dbl && sum >= 200) sum = sum - 200;
    return sum;
  endfunction

  function automatic int faddr(int x, int vv);
    int a;
    if (m_bmp) begin
      a = (x >> 4) + (vv >> 4) * 50;
      if (a > 1899) a = 1899;
    end else begin
      a = m_alt ? (30000 - (x >> 1) + (vv >> 1) * 400) : ((x >> 1) + (vv >> 1) * 400);
      if (a < 0) a = 0;
      if (a > 119999) a = 119999;
    end
    return a;
  endfunction

  function automatic int fpix(logic [7:0] d, bit act, bit g, bit bmp);
    logic [7:0] b;
    b = bmp ? (d[0] ? 8'hFF : 8'h00) : d;
    if (g) begin
      b[7] = d[4];
      b[6] = d[3];
      b[5] = ~d[1];
    end
    if (!act) b = 8'h00;
    return int'(b);
  endfunction

  task automatic step(int hh, int vv, int ss);
    int xc, a;
    bit act, g;
    @(negedge clk);
    if (ea_v) check(int'(addr) == ea, tag, int'(addr), ea);
    if (ev[2]) check(int'(rgb) == er[2], eact[2] ? tag : "R8 blanking", int'(rgb), er[2]);
    h = 11'(hh); v = 11'(vv); sine = 4'(ss);
    xc  = (hh == 0) ? 0 : xm;
    a   = faddr(xc, vv);
    act = (hh < 800) && (vv < 600);
    g   = m_grid && ((hh % 20 == 0) || (vv % 10 == 0));
    er[2] = er[1]; ev[2] = ev[1]; eact[2] = eact[1];
    er[1] = er[0]; ev[1] = ev[0]; eact[1] = eact[0];
    er[0] = fpix(memf(a), act, g, m_bmp); ev[0] = 1'b1; eact[0] = act;
    ea = a; ea_v = 1'b1;
    xm = fnext(xc, ss);
    if (hh == 0 && vv == 600) begin
      m_bmp = ~keys_n[0]; m_dbl = ~keys_n[1]; m_wig = ~keys_n[2];
      m_grid = ~keys_n[3]; m_alt = ~keys_n[4];
    end
  endtask

  // smode 99 selects a random offset per pixel
  task automatic scan(int vv, string t, int smode);
    tag = t;
    for (int hh = 0; hh < 1056; hh++) begin
      int s = (smode == 99) ? ($urandom_range(0, 15) - 8) : smode;
      step(hh, vv, s);
    end
  endtask

  task automatic latch(logic [4:0] k, string t);
    keys_n = k;
    tag = t;
    step(0, 600, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; keys_n = '0; h = '0; v = 11'd700; sine = '0;
    xm = 0; m_bmp = 0; m_dbl = 0; m_wig = 0; m_grid = 0; m_alt = 0;
    ea = 0; ea_v = 0;
    for (int i = 0; i < 3; i++) begin er[i] = 0; ev[i] = 0; eact[i] = 0; end
    repeat (3) @(negedge clk);
    check(addr == '0, "R10 reset address", int'(addr), 0);
    check(rgb == '0, "R10 reset pixel", int'(rgb), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // keys all pressed but not yet sampled: effects stay off
    scan(7, "R10 effects off after reset / R1 keys held unsampled", 5);

    latch(5'b11111, "R1 latch plain");
    scan(0, "R2 plain frame", 0);
    scan(1, "R2 plain frame", 0);
    scan(301, "R2 plain frame", 0);

    keys_n = 5'b00000;
    scan(44, "R1 keys changed mid-frame ignored", 3);

    latch(5'b11110, "R1 latch bitmap");
    scan(0, "R4 bitmap view", 0);
    scan(16, "R4 bitmap view", 0);
    scan(599, "R9 bitmap clamp", 0);

    latch(5'b01111, "R1 latch alt bank");
    scan(10, "R3 alternate bank", 0);
    scan(598, "R3 alternate bank", 0);

    latch(5'b11101, "R1 latch repetition");
    scan(100, "R5 repetition fold", 0);
    scan(555, "R5 repetition fold", 0);

    latch(5'b11011, "R1 latch wobble");
    scan(200, "R6 wobble random offset", 99);
    scan(123, "R6 wobble negative clamp", -8);
    scan(599, "R9 frame clamp under wobble", 7);

    latch(5'b10111, "R1 latch grid");
    scan(30, "R7 grid row", 0);
    scan(33, "R7 grid columns", 0);

    latch(5'b10110, "R1 latch grid over bitmap");
    scan(40, "R7 grid over bitmap", 0);

    for (int i = 0; i < 8; i++) begin
      latch(5'($urandom_range(0, 31)), "R1 latch random");
      scan($urandom_range(0, 620), "R5 R6 R7 mixed effects", 99);
    end

    tag = "R8 flush";
    repeat (4) step(900, 700, 0);
    summary();
    $finish;
  end
endmodule